// File: doc/BRIEF.md
# Binned Multi-Rate Row Refresh Scheduler

This block decides which DRAM rows get a refresh in each refresh round, and in what order. Charge leaks out of every cell, so every row needs a refresh now and then. Only a few rows hold weak cells that need the fast rate. The block keeps a small table that gives each row a retention class. Rows in a strong class are refreshed only in some rounds, which frees bank time that a single worst-case rate would use up.

A round tick arrives every 64 ms. On each tick the scheduler walks the rows from address 0 upward. A 2-bit round counter (modulo 4) decides which classes are due in the current round. A row that is not due costs one cycle and raises no request. A row that is due is offered on a request/acknowledge handshake with its address. The table is filled through a configuration write port once the retention classes are known. A tick that arrives during a walk is remembered as one pending round, and a sticky overrun flag records that it happened.

Top module: `rfsh_bin_sched`

## Requirements
- R1: After reset, `req`, `busy` and `overrun` are low and every table entry holds class 0, so every row is requested in every round until the table is written.
- R2: A cycle with `cfg_we` high stores `cfg_bin` as the class of row `cfg_row`, and all later rounds use it.
- R3: Class codes and their periods are: 0 = every round (64 ms), 1 = rounds whose counter value is even (128 ms), 2 = only the round whose counter is 0 (256 ms), 3 = treated like 0. The round counter is 0 after reset and advances by one, modulo 4, at the end of each round.
- R4: Within a round, requests come in strictly ascending row address order. Every due row is requested exactly once, and a row that is not due raises no request.
- R5: Once `req` rises, it stays high with `req_row` stable until a cycle with `ack` high. `req` is low in the following cycle.
- R6: A `tick` while `busy` is low starts a round, and `busy` is high after the next clock edge.
- R7: A `tick` while `busy` is high sets the sticky `overrun` flag and leaves one round pending. The pending round starts after a single idle cycle, once the current round ends.
- R8: Several ticks during one busy round leave only one pending round, not several.
- R9: `ack` while `req` is low is ignored. It neither skips a row nor ends a request early.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_row | input | ROW_W | Row whose class is written |
| cfg_bin | input | 2 | Class code to store |
| tick | input | 1 | Round tick, one pulse per 64 ms |
| req | output | 1 | Refresh request |
| req_row | output | ROW_W | Row address of the pending request |
| ack | input | 1 | Refresh accepted |
| busy | output | 1 | A round walk is in progress |
| overrun | output | 1 | Sticky: a tick arrived during a round |

## Verification
A wrong round counter or a corrupted table entry shows up on the next round. Because the bench predicts the exact sequence of `req_row` values, the first missing or extra address is caught within that round. A faulty walker shows up within one handshake: rows come out of order, the address moves while `req` waits, or a stray `ack` skips a row. A lost or duplicated pending round shows at the ports one cycle after the current round ends, as `busy` staying low or coming back too often.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

  typedef enum logic [1:0] {
    CLS_FAST = 2'd0,
    CLS_MID  = 2'd1,
    CLS_SLOW = 2'd2,
    CLS_RSVD = 2'd3
  } ret_class_t;

  typedef enum logic [1:0] {
    WK_IDLE = 2'd0,
    WK_SCAN = 2'd1,
    WK_REQ  = 2'd2
  } walk_state_t;

  localparam int RND_W = 2;

  // True when a row of class cls needs refresh in round rnd.
  function automatic logic class_due(ret_class_t cls, logic [RND_W-1:0] rnd);
    case (cls)
      CLS_MID:  class_due = (rnd[0] == 1'b0);
      CLS_SLOW: class_due = (rnd == '0);
      default:  class_due = 1'b1;
    endcase
  endfunction

  // Next round number, wrapping modulo 4.
  function automatic logic [RND_W-1:0] rnd_next(logic [RND_W-1:0] rnd);
    rnd_next = rnd + 1'b1;
  endfunction

endpackage

// File: rtl/rfsh_class_table.sv
module rfsh_class_table
  import rfsh_pkg::*;
#(
  parameter int ROWS  = 64,
  parameter int ROW_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [ROW_W-1:0] wr_row,
  input  ret_class_t       wr_cls,
  input  logic [ROW_W-1:0] rd_row,
  output ret_class_t       rd_cls
);

  ret_class_t ent [ROWS];

  always_ff @(posedge clk) begin
    for (int i = 0; i < ROWS; i++) begin
      if (!rst_n) begin
        ent[i] <= CLS_FAST;
      end else if (wr_en && (wr_row == ROW_W'(i))) begin
        ent[i] <= wr_cls;
      end
    end
  end

  assign rd_cls = ent[rd_row];

endmodule

// File: rtl/rfsh_round_ctrl.sv
module rfsh_round_ctrl
  import rfsh_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             busy,
  input  logic             done,
  output logic             start,
  output logic [RND_W-1:0] rnd,
  output logic             overrun
);

  logic pending;
  logic late_tick;

  assign late_tick = tick & busy;
  assign start     = ~busy & (tick | pending);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rnd     <= '0;
      pending <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (done) rnd <= rnd_next(rnd);
      if (start) pending <= 1'b0;
      else if (late_tick) pending <= 1'b1;
      if (late_tick) overrun <= 1'b1;
    end
  end

endmodule

// File: rtl/rfsh_row_walker.sv
module rfsh_row_walker
  import rfsh_pkg::*;
#(
  parameter int ROWS  = 64,
  parameter int ROW_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             ack,
  input  logic [RND_W-1:0] rnd,
  input  ret_class_t       cur_cls,
  output logic [ROW_W-1:0] row,
  output logic             req,
  output logic             busy,
  output logic             done
);

  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

  walk_state_t st;
  logic        due;
  logic        last;

  assign due  = class_due(cur_cls, rnd);
  assign last = (row == LAST_ROW);
  assign req  = (st == WK_REQ);
  assign busy = (st != WK_IDLE);
  assign done = ((st == WK_SCAN) && last && !due) ||
                ((st == WK_REQ) && ack && last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= WK_IDLE;
      row <= '0;
    end else begin
      case (st)
        WK_IDLE: begin
          if (start) begin
            st  <= WK_SCAN;
            row <= '0;
          end
        end
        WK_SCAN: begin
          if (due) st <= WK_REQ;
          else if (last) st <= WK_IDLE;
          else row <= row + 1'b1;
        end
        WK_REQ: begin
          if (ack) begin
            if (last) begin
              st <= WK_IDLE;
            end else begin
              st  <= WK_SCAN;
              row <= row + 1'b1;
            end
          end
        end
        default: st <= WK_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rfsh_bin_sched.sv
module rfsh_bin_sched
  import rfsh_pkg::*;
#(
  parameter  int ROWS  = 64,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [ROW_W-1:0] cfg_row,
  input  logic [1:0]       cfg_bin,
  input  logic             tick,
  output logic             req,
  output logic [ROW_W-1:0] req_row,
  input  logic             ack,
  output logic             busy,
  output logic             overrun
);

  // Internal events, named for the checker.
  logic             round_start;
  logic             round_done;
  logic [RND_W-1:0] round_num;
  logic [ROW_W-1:0] scan_row;
  ret_class_t       scan_cls;

  rfsh_class_table #(.ROWS(ROWS), .ROW_W(ROW_W)) u_table (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cfg_we),
    .wr_row (cfg_row),
    .wr_cls (ret_class_t'(cfg_bin)),
    .rd_row (scan_row),
    .rd_cls (scan_cls)
  );

  rfsh_round_ctrl u_round (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .busy    (busy),
    .done    (round_done),
    .start   (round_start),
    .rnd     (round_num),
    .overrun (overrun)
  );

  rfsh_row_walker #(.ROWS(ROWS), .ROW_W(ROW_W)) u_walk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (round_start),
    .ack     (ack),
    .rnd     (round_num),
    .cur_cls (scan_cls),
    .row     (scan_row),
    .req     (req),
    .busy    (busy),
    .done    (round_done)
  );

  assign req_row = scan_row;

endmodule

// File: rtl/rfsh_sched_chk.sv
module rfsh_sched_chk
  import rfsh_pkg::*;
#(
  parameter int ROW_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             ack,
  input logic             cfg_we,
  input logic             req,
  input logic [ROW_W-1:0] req_row,
  input logic             busy,
  input logic             overrun,
  input logic             round_done,
  input logic [RND_W-1:0] round_num,
  input logic [ROW_W-1:0] scan_row,
  input ret_class_t       scan_cls
);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req && !ack |=> req && $stable(req_row));

  p_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req && ack |=> !req);

  p_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && tick |=> busy);

  p_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && tick |=> overrun);

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  p_req_in_round_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> busy);

  p_ascend_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !round_done |=> scan_row >= $past(scan_row));

  p_due_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) && !$past(cfg_we) |-> class_due(scan_cls, round_num));

  p_round_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    round_done |=> round_num == rnd_next($past(round_num)));

  p_round_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !round_done |=> $stable(round_num));

endmodule

bind rfsh_bin_sched rfsh_sched_chk #(.ROW_W(ROW_W)) u_sched_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick),
  .ack        (ack),
  .cfg_we     (cfg_we),
  .req        (req),
  .req_row    (req_row),
  .busy       (busy),
  .overrun    (overrun),
  .round_done (round_done),
  .round_num  (round_num),
  .scan_row   (scan_row),
  .scan_cls   (scan_cls)
);

// File: tb/test_rfsh_bin_sched.sv
`timescale 1ns/1ps
module test_rfsh_bin_sched;

  localparam int ROWS  = 64;
  localparam int ROW_W = $clog2(ROWS);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_we = 1'b0;
  logic [ROW_W-1:0] cfg_row = '0;
  logic [1:0]       cfg_bin = '0;
  logic             tick = 1'b0;
  logic             ack = 1'b0;
  logic             req;
  logic [ROW_W-1:0] req_row;
  logic             busy;
  logic             overrun;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int rnd = 0;
  int model [ROWS];

  always #2.5 clk = ~clk;

  rfsh_bin_sched #(.ROWS(ROWS)) i_rfsh_bin_sched (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_row(cfg_row),
    .cfg_bin(cfg_bin), .tick(tick), .req(req), .req_row(req_row),
    .ack(ack), .busy(busy), .overrun(overrun)
  );

  task automatic wrap_up();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog: act=%0d cycles exp<150000", cyc);
      wrap_up();
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // Period in rounds per class; code 3 behaves as code 0.
  function automatic bit row_due(int cls, int r);
    int per;
    per = (cls == 1) ? 2 : (cls == 2) ? 4 : 1;
    return (r % per) == 0;
  endfunction

  function automatic int next_due(int from, int r);
    for (int i = from; i < ROWS; i++)
      if (row_due(model[i], r)) return i;
    return ROWS;
  endfunction

  function automatic int due_count(int r);
    int n = 0;
    for (int i = 0; i < ROWS; i++) if (row_due(model[i], r)) n++;
    return n;
  endfunction

  task automatic write_cls(input int row, input int cls);
    @(negedge clk);
    cfg_we = 1'b1; cfg_row = ROW_W'(row); cfg_bin = 2'(cls);
    model[row] = cls;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic kick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    chk(busy === 1'b1, "R6 busy after tick", busy, 1);
  endtask

  // Serve one running round; late_ticks ticks are injected while busy.
  task automatic serve(input int late_ticks, output int got);
    int exp_row, it, tl, hold;
    logic [ROW_W-1:0] held;
    exp_row = next_due(0, rnd);
    it = 0; tl = late_ticks; got = 0;
    while (busy) begin
      if (req) begin
        chk(int'(req_row) == exp_row, "R4 row order", req_row, exp_row);
        got++;
        exp_row = next_due(exp_row + 1, rnd);
        held = req_row;
        hold = $urandom % 4;
        for (int h = 0; h < hold; h++) begin
          @(negedge clk);
          chk(req === 1'b1 && req_row == held, "R5 req held stable", req_row, held);
        end
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        chk(req === 1'b0, "R5 req drops after ack", req, 0);
      end else begin
        ack  = (($urandom % 4) == 0);   // stray ack, R9
        tick = (it >= 3 && tl > 0);
        if (tick) tl--;
        @(negedge clk);
        ack = 1'b0; tick = 1'b0;
      end
      it++;
    end
    chk(exp_row == ROWS, "R4 all due rows served", exp_row, ROWS);
    chk(got == due_count(rnd), "R3 request count", got, due_count(rnd));
    rnd = (rnd + 1) % 4;
  endtask

  initial begin
    int got;
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < ROWS; i++) model[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req === 1'b0, "R1 req after reset", req, 0);
    chk(busy === 1'b0, "R1 busy after reset", busy, 0);
    chk(overrun === 1'b0, "R1 overrun after reset", overrun, 0);

    // R9: ack while idle changes nothing.
    ack = 1'b1; @(negedge clk); ack = 1'b0;
    chk(req === 1'b0 && busy === 1'b0, "R9 idle ack ignored", busy, 0);

    // Rounds 0 and 1 on the reset table: every row each time (R1).
    kick(); serve(0, got);
    chk(got == ROWS, "R1 round0 all rows", got, ROWS);
    kick(); serve(0, got);
    chk(got == ROWS, "R1 reset table all class 0", got, ROWS);

    // R2/R3: random classes, four rounds.
    for (int i = 0; i < ROWS; i++) write_cls(i, $urandom % 4);
    for (int k = 0; k < 4; k++) begin
      kick(); serve(0, got);
    end

    // Directed: class 1 everywhere, row 0 class 2, last row class 3 (R3).
    for (int i = 0; i < ROWS; i++) write_cls(i, 1);
    write_cls(0, 2);
    write_cls(ROWS - 1, 3);
    kick(); serve(0, got);                 // rnd 2
    chk(got == ROWS - 1, "R3 even round skips class 2", got, ROWS - 1);
    kick(); serve(0, got);                 // rnd 3
    chk(got == 1, "R3 class 3 every round", got, 1);

    // All slow: one full round, then one empty round (R4 skips).
    for (int i = 0; i < ROWS; i++) write_cls(i, 2);
    kick(); serve(0, got);                 // rnd 0
    chk(got == ROWS, "R3 class 2 due in round 0", got, ROWS);
    kick(); serve(0, got);                 // rnd 1
    chk(got == 0, "R4 no request when none due", got, 0);

    // Overrun and pending round (R7, R8).
    for (int i = 0; i < ROWS; i++) write_cls(i, $urandom % 4);
    chk(overrun === 1'b0, "R7 no overrun yet", overrun, 0);
    kick(); serve(1, got);
    chk(overrun === 1'b1, "R7 overrun set", overrun, 1);
    chk(busy === 1'b0, "R7 idle cycle between rounds", busy, 0);
    @(negedge clk);
    chk(busy === 1'b1, "R7 pending round starts", busy, 1);
    serve(3, got);
    @(negedge clk);
    chk(busy === 1'b1, "R8 one pending round", busy, 1);
    serve(0, got);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(busy === 1'b0, "R8 no extra round", busy, 0);
    end
    chk(overrun === 1'b1, "R7 overrun sticky", overrun, 1);

    wrap_up();
  end

endmodule